// File: doc/BRIEF.md
# Oversampling Serial Receiver with Tagged Character Queue

This block is the receive half of an asynchronous serial channel. An external divider supplies a single-cycle enable at sixteen times the bit rate. The block samples the idle-high line on that enable. A high-to-low transition starts a frame. The block confirms the start bit with a sample halfway through it, then takes every data, parity and stop bit at its centre.

Each finished character goes into a first-in first-out queue together with three condition tags: parity mismatch, bad stop bit and line break. Because the tags sit next to the character they describe, the host always sees the error state of the entry at the head of the queue. It never sees a merged error state for the whole queue.

Word length and parity mode are static inputs. The host reads through a pop strobe and watches a data-ready flag and the queue level. A sticky overflow flag records characters that were lost because the queue was full. A status-read strobe clears that flag.

Top module: `uart_rx_tagq`

## Requirements
- R1: After reset, `level` is 0, `data_ready` is 0 and `overrun` is 0.
- R2: A low pulse on `rxd` that ends before the eighth oversampling tick after the falling edge produces no character and leaves `level` unchanged.
- R3: Data bits arrive least significant first. `word_len` code 0,1,2,3 selects 5,6,7,8 data bits. Unused upper bits of `rd_data` read as 0.
- R4: When `par_en` is 1, a parity bit follows the data. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. A mismatch sets `rd_perr` for that entry. When `par_en` is 0, `rd_perr` is 0.
- R5: A stop bit sampled as 0 sets `rd_ferr` for that entry. The character is still stored.
- R6: When the data bits, any parity bit and the stop bit are all 0, `rd_brk` is set for that entry. `rd_ferr` is also set.
- R7: Entries leave the queue in arrival order. Each entry's tags stay with its data. `pop` removes the head entry.
- R8: `data_ready` is 1 exactly while `level` is nonzero. `level` counts the stored entries, up to `DEPTH`.
- R9: A character that completes while `level` equals `DEPTH` is discarded and sets `overrun`. `overrun` stays set until `status_rd` is pulsed, which clears it.
- R10: After a frame with a bad stop bit, the receiver waits for the line to return high. The next falling edge then starts a frame that is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| pop | input | 1 | Remove the head entry |
| status_rd | input | 1 | Clear the overflow flag |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity tag |
| rd_ferr | output | 1 | Head entry stop-bit tag |
| rd_brk | output | 1 | Head entry break tag |
| data_ready | output | 1 | Queue not empty |
| level | output | $clog2(DEPTH)+1 | Stored entry count |
| overrun | output | 1 | Sticky overflow flag |

## Verification
The bench uses a short low glitch on the line. A receiver that skipped the mid-start check would store a spurious character from it.

The stimulus covers 5-bit words, where a wrong final shift leaves stray high bits in the data. It covers both parity senses, so inverted odd/even handling shows up as false parity tags. It also separates a plain bad stop bit from a true break: a zero stop bit with nonzero data must not raise the break tag, and an all-zero frame must raise both tags.

Finally the bench fills the queue and sends one more character. A design that overwrote the head or wrapped its pointers wrong would corrupt the arrival order or the level. A design that cleared the flag on its own would lose the overflow indication.

// File: rtl/uart_rx_tagq.sv
module uart_rx_tagq #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic [1:0]    word_len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          pop,
  input  logic          status_rd,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_brk,
  output logic          data_ready,
  output logic [LW-1:0] level,
  output logic          overrun
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t        st;
  logic       rx_q1, rx_s, ln_prev;
  logic [3:0] cnt;
  logic [2:0] nbit;
  logic [7:0] sh;
  logic       pbit;
  logic       wr_en;
  logic [10:0] wr_word;
  logic [10:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  wire [2:0] last_bit = 3'd4 + {1'b0, word_len};
  wire [7:0] data_al  = sh >> (2'd3 - word_len);
  wire       mid      = tick16 && cnt == 4'd15;
  wire       full     = level == LW'(DEPTH);
  wire       do_pop   = pop && level != '0;
  wire       do_wr    = wr_en && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q1 <= 1'b1;
      rx_s  <= 1'b1;
    end else begin
      rx_q1 <= rxd;
      rx_s  <= rx_q1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ln_prev <= 1'b1;
      cnt     <= '0;
      nbit    <= '0;
      sh      <= '0;
      pbit    <= 1'b0;
      wr_en   <= 1'b0;
      wr_word <= '0;
    end else begin
      wr_en <= 1'b0;
      if (tick16) begin
        ln_prev <= rx_s;
        cnt     <= cnt + 4'd1;
      end
      case (st)
        S_IDLE: if (tick16 && ln_prev && !rx_s) begin
          st  <= S_START;
          cnt <= 4'd1;
        end
        S_START: if (tick16 && cnt == 4'd7) begin
          cnt  <= '0;
          nbit <= '0;
          sh   <= '0;
          st   <= rx_s ? S_IDLE : S_DATA;
        end
        S_DATA: if (mid) begin
          sh   <= {rx_s, sh[7:1]};
          nbit <= nbit + 3'd1;
          if (nbit == last_bit) st <= par_en ? S_PAR : S_STOP;
        end
        S_PAR: if (mid) begin
          pbit <= rx_s;
          st   <= S_STOP;
        end
        S_STOP: if (mid) begin
          wr_en   <= 1'b1;
          wr_word <= {data_al == 8'd0 && !(par_en && pbit) && !rx_s,
                      !rx_s,
                      par_en && ((^data_al ^ pbit) != par_odd),
                      data_al};
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_wr)  wp <= wp + 1'b1;
      if (do_pop) rp <= rp + 1'b1;
      level <= level + LW'(do_wr) - LW'(do_pop);
      if (status_rd) overrun <= 1'b0;
      if (wr_en && full) overrun <= 1'b1;
    end
  end

  assign {rd_brk, rd_ferr, rd_perr, rd_data} = mem[rp];
  assign data_ready = level != '0;

  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  a_r8_ready_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && level == '0) |=> data_ready);
  a_r9_overrun_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(level) == LW'(DEPTH));
  a_r9_discard_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !pop) |=> level == LW'(DEPTH));
  a_r6_break_has_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && rd_brk) |-> rd_ferr);
  a_r7_pop_drops_level: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !wr_en) |=> level == $past(level) - 1'b1);

endmodule

// File: tb/tb_uart_rx_tagq.sv
module tb_uart_rx_tagq;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h2C},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 8'h55},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  logic clk = 0, rst_n = 0, tick16 = 0, rxd = 1;
  logic [1:0] word_len = 2'd3;
  logic par_en = 0, par_odd = 0, pop = 0, status_rd = 0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, data_ready, overrun;
  logic [LW-1:0] level;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  uart_rx_tagq #(.DEPTH(DEPTH)) dut (.*);

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick16 = ~tick16;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (32) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] wl, input logic pe, input logic po,
                      input logic flip, input logic stop, input logic [7:0] d);
    logic p;
    p = (^(d & (8'hFF >> (2'd3 - wl)))) ^ po ^ flip;
    word_len = wl; par_en = pe; par_odd = po;
    bit_out(1'b0);
    for (int i = 0; i < 5 + wl; i++) bit_out(d[i]);
    if (pe) bit_out(p);
    bit_out(stop);
    bit_out(1'b1);
  endtask

  task automatic do_pop();
    pop = 1;
    @(negedge clk);
    pop = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 level", level, 0);
    chk("R1 ready", data_ready, 0);
    chk("R1 overrun", overrun, 0);

    foreach (VEC[k]) begin
      logic [1:0] wl; logic pe, po, fl, sp; logic [7:0] d, m; logic p;
      {wl, pe, po, fl, sp, d} = VEC[k];
      m = d & (8'hFF >> (2'd3 - wl));
      p = (^m) ^ po ^ fl;
      send(wl, pe, po, fl, sp, d);
      chk("R8 level", level, 1);
      chk("R8 ready", data_ready, 1);
      chk("R3 data", rd_data, m);
      chk("R4 parity tag", rd_perr, pe && fl);
      chk("R5 stop tag", rd_ferr, !sp);
      chk("R6 break tag", rd_brk, m == 0 && !(pe && p) && !sp);
      do_pop();
      chk("R8 empty", data_ready, 0);
    end

    rxd = 0;
    repeat (6) @(negedge clk);
    rxd = 1;
    repeat (400) @(negedge clk);
    chk("R2 glitch", level, 0);

    send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h40);
    send(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h6E);
    chk("R10 level", level, 2);
    do_pop();
    chk("R10 resync data", rd_data, 8'h6E);
    chk("R10 resync tag", rd_ferr, 0);
    do_pop();

    for (int i = 0; i < DEPTH; i++) send(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'(i * 7 + 3));
    chk("R8 full level", level, DEPTH);
    chk("R9 no overrun yet", overrun, 0);
    send(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hEE);
    chk("R9 overrun set", overrun, 1);
    chk("R9 level held", level, DEPTH);
    repeat (50) @(negedge clk);
    chk("R9 sticky", overrun, 1);
    status_rd = 1;
    @(negedge clk);
    status_rd = 0;
    @(negedge clk);
    chk("R9 cleared", overrun, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R7 order", rd_data, 8'(i * 7 + 3));
      do_pop();
    end
    chk("R7 drained", level, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule